// File: doc/BRIEF.md
# Dual-Port Burst-of-Two SRAM Model

This block is a synthesizable model of a memory with a dedicated read port and a dedicated write port. Every access moves a burst of two words, and the array keeps each burst as one double-width entry. It runs on a single clock at twice the access rate. An internal phase bit divides that clock into a K half, where requests start, and a K# half. One address bus is shared by the two ports in time. The read address is taken in the K half and the write address in the K# half, so one read and one write can both be issued in each access cycle.

Write data and its active-low lane masks arrive one word per half. The two words are then committed together in one update of the array. Read data comes back as two words in consecutive halves, with a fixed latency. An output-valid flag stands in for a tri-state output: rdData is meaningless while rdValid is low. The kPhase output lets a controller line its requests up with the K half.

Top module: `qdr_burst_sram`

## Requirements
- R1: kPhase is 0 during reset and toggles on every clock edge after reset. kPhase = 0 marks a K half, and the clock edge that ends a K half is a K edge.
- R2: A read is accepted when rdSelN is 0 at a K edge. The read address is taken from addr at that same edge.
- R3: If a read is accepted at edge e, rdData holds the low word (bits [W-1:0] of the burst) from edge e+3, and the high word from edge e+4. rdValid is 1 in both of those halves.
- R4: A write is accepted when wrSelN is 0 at a K edge. Word 0 and its masks are taken at that K edge. The write address, word 1 and its masks are taken at the next edge, which is the K# edge.
- R5: Mask bits are active low. Mask bit i covers bits [9i+8:9i] of its word. A lane whose mask bit is 1 keeps its old contents.
- R6: Setting every mask bit to 1 in one half leaves the whole word for that half unchanged, while the other word of the burst is still written.
- R7: rdValid is 0 from reset. After the high word of the last pending burst, rdValid returns to 0 at the next edge.
- R8: Reads accepted at consecutive K edges produce output with no gap between the bursts.
- R9: When a read and a write in the same cycle use the same address, the read returns the old contents. A read accepted at the next K edge returns the new contents.
- R10: All entries of the array read as zero before they are first written.
- R11: rdSelN and wrSelN have no effect at a K# edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the access rate |
| rstN | input | 1 | Synchronous reset, active low |
| rdSelN | input | 1 | Read request, active low, sampled at K edges |
| wrSelN | input | 1 | Write request, active low, sampled at K edges |
| addr | input | ADDR_W | Shared address: read address in the K half, write address in the K# half |
| wrData | input | WORD_W | Write data word, one word per half |
| wrMaskN | input | WORD_W/LANE_W | Lane masks for the word on wrData, active low |
| kPhase | output | 1 | 0 during a K half, 1 during a K# half |
| rdData | output | WORD_W | Read data word |
| rdValid | output | 1 | Read output enable |

## Verification
The bench targets a read and a write to the same address in the same cycle. A design that commits the write before the array is sampled returns the new data there instead of the old. It also targets selects asserted in the K# half. A design that samples the selects in every half would start phantom reads or store stray bursts. Back-to-back reads check that the high word of one burst survives while the next burst is being looked up; a design with a single output stage would overwrite it. Partial masks and fully masked halves show whether lanes are decoded per word or smeared across the burst.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef struct packed {
    logic kEdge;     // current edge closes a K half
    logic rdLookup;  // sample the array for the pending read
    logic wrCommit;  // write both words of the pending burst
    logic outLo;     // present low word of the burst
    logic outHi;     // present high word of the burst
  } qdrStrobes_t;
endpackage

// File: rtl/qdr_ctrl.sv
module qdr_ctrl
  import qdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdSelN,
  input  logic        wrSelN,
  output logic        kPhase,
  output qdrStrobes_t st
);
  localparam int RD_STAGES = 4;

  logic                 phase;
  logic [RD_STAGES-1:0] rdPipe;
  logic                 wrPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 1'b0;
      rdPipe <= '0;
      wrPend <= 1'b0;
    end else begin
      phase  <= ~phase;
      rdPipe <= {rdPipe[RD_STAGES-2:0], (~phase & ~rdSelN)};
      wrPend <= ~phase & ~wrSelN;
    end
  end

  always_comb begin
    st.kEdge    = ~phase;
    st.rdLookup = rdPipe[0];
    st.wrCommit = wrPend;
    st.outLo    = rdPipe[2];
    st.outHi    = rdPipe[3];
  end

  assign kPhase = phase;

  // R8: the two words of a burst never compete for the same half
  a_r8_one_word_per_half: assert property (@(posedge clk) disable iff (!rstN)
    !(st.outLo && st.outHi));
  // R3: high word always follows the low word
  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rstN)
    st.outLo |=> st.outHi);
  // R2: array lookup happens in the K# half that follows the request
  a_r2_lookup_in_kbar: assert property (@(posedge clk) disable iff (!rstN)
    st.rdLookup |-> phase);
  // R4: commit only at a K# edge
  a_r4_commit_in_kbar: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCommit |-> phase);
endmodule

// File: rtl/qdr_datapath.sv
module qdr_datapath
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qdrStrobes_t              st,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W/LANE_W-1:0] wrMaskN,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WIDE  = 2 * WORD_W;

  logic [WIDE-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0] rdAddrQ;
  logic [WORD_W-1:0] loWord;
  logic [LANES-1:0]  loMaskN;
  logic [WIDE-1:0]   rdWide;
  logic [WORD_W-1:0] rdHiQ;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (st.kEdge) begin
      rdAddrQ <= addr;
      loWord  <= wrData;
      loMaskN <= wrMaskN;
    end
    if (st.rdLookup) rdWide <= mem[rdAddrQ];
    if (st.wrCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!loMaskN[l]) mem[addr][l*LANE_W +: LANE_W] <= loWord[l*LANE_W +: LANE_W];
        if (!wrMaskN[l]) mem[addr][WORD_W + l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.outLo) begin
      rdData <= rdWide[WORD_W-1:0];
      rdHiQ  <= rdWide[WIDE-1:WORD_W];
    end else if (st.outHi) begin
      rdData <= rdHiQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= st.outLo | st.outHi;
  end

  // R7: output enable only switches at the start of a K half
  a_r7_valid_switch_on_k: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid != $past(rdValid)) |-> st.kEdge);
  // R3: a burst keeps the output enabled for two halves
  a_r3_valid_two_halves: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdSelN,
  input  logic                     wrSelN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W/LANE_W-1:0] wrMaskN,
  output logic                     kPhase,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid
);
  qdrStrobes_t st;

  qdr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .kPhase (kPhase),
    .st     (st)
  );

  qdr_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .addr    (addr),
    .wrData  (wrData),
    .wrMaskN (wrMaskN),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: tb/sim_qdr_burst_sram.sv
`timescale 1ns/1ps
module sim_qdr_burst_sram;
  localparam int AW = 10;
  localparam int W  = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdSelN = 1'b1;
  logic          wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wrData = '0;
  logic [1:0]    wrMaskN = 2'b11;
  logic          kPhase;
  logic [W-1:0]  rdData;
  logic          rdValid;

  qdr_burst_sram #(.ADDR_W(AW), .WORD_W(W), .LANE_W(9)) u0 (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .wrData(wrData), .wrMaskN(wrMaskN), .kPhase(kPhase), .rdData(rdData), .rdValid(rdValid)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int edgeCnt = 0;
  bit done = 0;
  string curTag = "R10";

  // reference state
  logic [35:0] refMem [int];
  logic        expV [int];
  logic [W-1:0] expD [int];
  logic        pendRd, pendWr;
  logic [AW-1:0] pendRA;
  logic [W-1:0] pendW0;
  logic [1:0]  pendM0;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  function automatic logic [35:0] rdRef(input logic [AW-1:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 36'd0;
  endfunction

  // compare outputs against the model after every edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      tests++;
      if (kPhase !== edgeCnt[0]) begin
        fails++;
        $display("FAIL R1 [%s] edge %0d kPhase=%0b exp=%0b", curTag, edgeCnt, kPhase, edgeCnt[0]);
      end
      tests++;
      if (rdValid !== expV.exists(edgeCnt)) begin
        fails++;
        $display("FAIL R7 [%s] edge %0d rdValid=%0b exp=%0b", curTag, edgeCnt, rdValid, expV.exists(edgeCnt));
      end
      if (expV.exists(edgeCnt) && rdValid) begin
        tests++;
        if (rdData !== expD[edgeCnt]) begin
          fails++;
          $display("FAIL R3 [%s] edge %0d rdData=%h exp=%h", curTag, edgeCnt, rdData, expD[edgeCnt]);
        end
      end
    end
  end

  // one half-cycle: drive at negedge, model the edge that follows
  task automatic hs(input logic rs, input logic ws, input logic [AW-1:0] a,
                    input logic [W-1:0] d, input logic [1:0] m);
    int n;
    logic [35:0] cur;
    n = edgeCnt + 1;
    rdSelN = rs; wrSelN = ws; addr = a; wrData = d; wrMaskN = m;
    if (kPhase == 1'b0) begin
      pendRd = !rs; pendRA = a; pendWr = !ws; pendW0 = d; pendM0 = m;
    end else begin
      if (pendRd) begin
        cur = rdRef(pendRA);
        expV[n+2] = 1'b1; expD[n+2] = cur[17:0];
        expV[n+3] = 1'b1; expD[n+3] = cur[35:18];
      end
      if (pendWr) begin
        cur = rdRef(a);
        if (!pendM0[0]) cur[8:0]   = pendW0[8:0];
        if (!pendM0[1]) cur[17:9]  = pendW0[17:9];
        if (!m[0])      cur[26:18] = d[8:0];
        if (!m[1])      cur[35:27] = d[17:9];
        refMem[int'(a)] = cur;
      end
      pendRd = 1'b0; pendWr = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic align();
    while (kPhase !== 1'b0) hs(1'b1, 1'b1, '0, '0, 2'b11);
  endtask

  task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                     input logic [W-1:0] d0, input logic [1:0] m0,
                     input logic [W-1:0] d1, input logic [1:0] m1);
    align();
    hs(!rd, !wr, ra, d0, m0);
    hs(1'b1, 1'b1, wa, d1, m1);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, '0, 0, '0, '0, 2'b11, '0, 2'b11);
  endtask

  initial begin
    pendRd = 0; pendWr = 0; pendRA = '0; pendW0 = '0; pendM0 = 2'b11;
    repeat (3) @(negedge clk);
    tests++;
    if (rdValid !== 1'b0 || kPhase !== 1'b0) begin
      fails++;
      $display("FAIL R7 reset state rdValid=%0b kPhase=%0b exp=0 0", rdValid, kPhase);
    end
    rstN = 1'b1;
    @(negedge clk);

    curTag = "R10";
    cyc(1, 10'd5, 0, '0, '0, 2'b11, '0, 2'b11);
    cyc(1, 10'd1023, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R4";
    cyc(0, '0, 1, 10'd5, 18'h1A5A5, 2'b00, 18'h2C3C3, 2'b00);
    cyc(1, 10'd5, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R5";
    cyc(0, '0, 1, 10'd5, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01);
    cyc(1, 10'd5, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R6";
    cyc(0, '0, 1, 10'd7, 18'h12345, 2'b00, 18'h0BEEF, 2'b11);
    cyc(1, 10'd7, 1, 10'd8, 18'h3FFFF, 2'b11, 18'h01111, 2'b00);
    cyc(1, 10'd8, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R8";
    cyc(1, 10'd5, 0, '0, '0, 2'b11, '0, 2'b11);
    cyc(1, 10'd7, 0, '0, '0, 2'b11, '0, 2'b11);
    cyc(1, 10'd8, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R9";
    cyc(1, 10'd7, 1, 10'd7, 18'h0AAAA, 2'b00, 18'h15555, 2'b00);
    cyc(1, 10'd7, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R11";
    align();
    hs(1'b1, 1'b1, 10'd9, '0, 2'b11);
    hs(1'b0, 1'b0, 10'd9, 18'h3ABCD, 2'b00);
    hs(1'b1, 1'b1, 10'd9, '0, 2'b11);
    hs(1'b0, 1'b0, 10'd9, 18'h3ABCD, 2'b00);
    idle(3);
    cyc(1, 10'd9, 0, '0, '0, 2'b11, '0, 2'b11);
    idle(3);

    curTag = "R2";
    for (int i = 0; i < 300; i++) begin
      cyc($urandom_range(0, 1), 10'($urandom_range(0, 7)),
          $urandom_range(0, 1), 10'($urandom_range(0, 7)),
          18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom));
    end
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule